// File: doc/BRIEF.md
# PPS-Aligned 64-bit Tick Timebase

This block keeps a 64-bit tick count that advances by one on every clock of the radio domain. Software reaches it through a 32-bit register bus. It places a 64-bit event time in two staging words, then issues a control write. That write either copies the staged time into the counter straight away or arms a copy that happens on the next rising edge of a pulse-per-second (PPS) input. Every PPS rising edge also snapshots the running count into a capture register, and it flips a detect bit that software can poll to confirm that the pulse is alive. A 64-bit tick-period register is stored for software and does not affect counting.

Several copies of the block share one bus. Each copy decodes its own 48-byte window, which starts at byte address `WIN_BASE + WIN_STRIDE * INST_IDX`. Because a copy answers only inside its window, the read data of all copies can be ORed together. The bus has no back-pressure: a write is taken on the cycle it is presented, and a read is answered on the next cycle with `bus_rvalid` high for exactly one cycle. Reading a low word freezes the matching high word in a shadow, so a low-then-high read pair returns one coherent 64-bit value.

Top module: `tick_timebase`

## Requirements
- R1: The block decodes only byte addresses from `WIN_BASE + WIN_STRIDE*INST_IDX` up to 47 bytes past that start. A read inside the window sets `bus_rvalid` on the next cycle, and an in-window offset that is not mapped reads 0. Outside the window `bus_rvalid` stays low, `bus_rdata` stays 0, and writes change nothing.
- R2: The counter increases by exactly one per clock. A read of offset 0x00 returns bits 31:0 of the count held in the cycle the read is presented, and the data appears the next cycle.
- R3: A read of offset 0x00 also latches count bits 63:32, and offset 0x04 returns that latched word rather than the live count.
- R4: Offsets 0x08 (low) and 0x0C (high) hold a write-only staged 64-bit time that reads 0. A write of 0x1 to control offset 0x10 makes the counter hold the staged value on the cycle after the write.
- R5: A write of 0x2 to offset 0x10 arms a load. The load stays pending, with the counter still incrementing, until a synchronized PPS rising edge. On the edge cycle the counter takes the staged value instead of incrementing. The edge acts two clocks after the clock that first samples `pps_in` high.
- R6: Any control write that is not 0x2 cancels a pending armed load, so a later PPS edge does not load the counter.
- R7: Every PPS rising edge captures the count of the edge cycle, whether or not a load is armed. Offset 0x14 reads the low word and latches the high word, and offset 0x18 returns the latched high word.
- R8: Offsets 0x1C (low) and 0x20 (high) form a 64-bit read-write period register. Each word is written independently.
- R9: Bit 0 of offset 0x24 toggles on every synchronized PPS rising edge, and the other bits read 0.
- R10: Reset clears the counter, the capture register, the period register, the detect bit and any pending arm. Writes to the read-only offsets 0x00, 0x04, 0x14, 0x18 and 0x24 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Radio-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_rvalid`, otherwise 0 |
| bus_rvalid | output | 1 | Read response, one cycle after an in-window read |

## Verification
The bench keeps its own model of the tick count and an exact cycle index, so every counter read is compared to a value that is known to the tick. A load placed one clock early or late, or a PPS path with the wrong number of synchronizer stages, shows up as an off-by-one count. The coherence test stages a low word of all ones, so the carry into the high word lands between the low and high reads; a high word taken from the live count would come back one too large. The arm tests wait well past the write before the pulse, then cancel an arm with 0x0 and with 0x1. A design that loaded at once, kept a stale arm, or skipped the capture on unarmed edges would return a count that differs from the model. Window tests probe a neighbouring copy's window and the first byte past the block's own, where a loose decoder would answer or take a write.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int WORD_IX_W = 4;
  typedef logic [WORD_IX_W-1:0] word_ix_t;

  // Word index inside the window (byte offset / 4).
  localparam word_ix_t WIX_NOW_LO = 4'd0;
  localparam word_ix_t WIX_NOW_HI = 4'd1;
  localparam word_ix_t WIX_EVT_LO = 4'd2;
  localparam word_ix_t WIX_EVT_HI = 4'd3;
  localparam word_ix_t WIX_CTRL   = 4'd4;
  localparam word_ix_t WIX_CAP_LO = 4'd5;
  localparam word_ix_t WIX_CAP_HI = 4'd6;
  localparam word_ix_t WIX_PER_LO = 4'd7;
  localparam word_ix_t WIX_PER_HI = 4'd8;
  localparam word_ix_t WIX_STATUS = 4'd9;

  localparam logic [31:0] CTRL_LOAD_NOW = 32'h1;
  localparam logic [31:0] CTRL_ARM_PPS  = 32'h2;
endpackage

// File: rtl/tt_pps_sync.sv
module tt_pps_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  output logic pps_rise,
  output logic pps_seen
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pps_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pps_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= 1'b0;
      pps_seen <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      if (pps_rise) pps_seen <= ~pps_seen;
    end
  end

  assign pps_rise = sync_q[SYNC_STAGES-1] & ~last_q;

  // A rising edge is a single-cycle event.
  p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> !pps_rise);
  p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> pps_seen != $past(pps_seen));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pps_rise |=> $stable(pps_seen));
endmodule

// File: rtl/tt_tick_core.sv
module tt_tick_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] staged,
  input  logic             ctrl_wr,
  input  logic             load_now,
  input  logic             arm_set,
  input  logic             pps_rise,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             armed
);
  logic take_pps;
  assign take_pps = pps_rise & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      capture <= '0;
      armed   <= 1'b0;
    end else begin
      if (load_now || take_pps) count <= staged;
      else                      count <= count + 1'b1;

      if (pps_rise) capture <= count;

      if (ctrl_wr)       armed <= arm_set;
      else if (take_pps) armed <= 1'b0;
    end
  end

  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_now && !(pps_rise && armed)) |=> count == $past(count) + 1'b1);
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load_now |=> count == $past(staged));
  p_pps_load_r5: assert property (@(posedge clk) disable iff (rst)
    (pps_rise && armed && !load_now) |=> count == $past(staged));
  p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
    (pps_rise && armed && !ctrl_wr) |=> !armed);
  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !arm_set) |=> !armed);
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> capture == $past(count));
endmodule

// File: rtl/tt_bus_regs.sv
module tt_bus_regs
  import tt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WIN_BASE   = 100,
  parameter int WIN_STRIDE = 48,
  parameter int INST_IDX   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [2*DATA_W-1:0] count,
  input  logic [2*DATA_W-1:0] capture,
  input  logic                pps_seen,
  output logic [2*DATA_W-1:0] staged,
  output logic                ctrl_wr,
  output logic                load_now,
  output logic                arm_set
);
  localparam int                WIN_START = WIN_BASE + WIN_STRIDE * INST_IDX;
  localparam logic [ADDR_W-1:0] WIN_LO_A  = ADDR_W'(WIN_START);
  localparam logic [ADDR_W-1:0] WIN_HI_A  = ADDR_W'(WIN_START + WIN_STRIDE);

  logic [ADDR_W-1:0] offset;
  word_ix_t          word;
  logic              hit, wr_hit;
  logic [DATA_W-1:0] evt_lo, evt_hi, per_lo, per_hi, now_hi_sh, cap_hi_sh;
  logic [DATA_W-1:0] rd_mux;

  assign hit    = (bus_addr >= WIN_LO_A) && (bus_addr < WIN_HI_A);
  assign offset = bus_addr - WIN_LO_A;
  assign word   = WORD_IX_W'(offset >> 2);
  assign wr_hit = bus_wr && hit;

  assign ctrl_wr  = wr_hit && (word == WIX_CTRL);
  assign load_now = ctrl_wr && (bus_wdata == DATA_W'(CTRL_LOAD_NOW));
  assign arm_set  = ctrl_wr && (bus_wdata == DATA_W'(CTRL_ARM_PPS));
  assign staged   = {evt_hi, evt_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_lo <= '0;
      evt_hi <= '0;
      per_lo <= '0;
      per_hi <= '0;
    end else if (wr_hit) begin
      case (word)
        WIX_EVT_LO: evt_lo <= bus_wdata;
        WIX_EVT_HI: evt_hi <= bus_wdata;
        WIX_PER_LO: per_lo <= bus_wdata;
        WIX_PER_HI: per_hi <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      WIX_NOW_LO: rd_mux = count[DATA_W-1:0];
      WIX_NOW_HI: rd_mux = now_hi_sh;
      WIX_CAP_LO: rd_mux = capture[DATA_W-1:0];
      WIX_CAP_HI: rd_mux = cap_hi_sh;
      WIX_PER_LO: rd_mux = per_lo;
      WIX_PER_HI: rd_mux = per_hi;
      WIX_STATUS: rd_mux = {{(DATA_W-1){1'b0}}, pps_seen};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      now_hi_sh  <= '0;
      cap_hi_sh  <= '0;
    end else begin
      bus_rvalid <= bus_rd && hit;
      bus_rdata  <= (bus_rd && hit) ? rd_mux : '0;
      if (bus_rd && hit && word == WIX_NOW_LO) now_hi_sh <= count[2*DATA_W-1:DATA_W];
      if (bus_rd && hit && word == WIX_CAP_LO) cap_hi_sh <= capture[2*DATA_W-1:DATA_W];
    end
  end

  p_miss_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (!bus_rvalid && bus_rdata == '0));
  p_answer_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit) |=> bus_rvalid);
  p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($stable(per_lo) && $stable(per_hi)));
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int WIN_BASE    = 100,
  parameter int WIN_STRIDE  = 48,
  parameter int INST_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int CNT_W = 2 * DATA_W;

  logic             pps_rise, pps_seen;
  logic             ctrl_wr, load_now, arm_set, armed;
  logic [CNT_W-1:0] staged, count, capture;

  tt_pps_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .pps_rise(pps_rise), .pps_seen(pps_seen)
  );

  tt_tick_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .staged(staged), .ctrl_wr(ctrl_wr),
    .load_now(load_now), .arm_set(arm_set), .pps_rise(pps_rise),
    .count(count), .capture(capture), .armed(armed)
  );

  tt_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
    .WIN_STRIDE(WIN_STRIDE), .INST_IDX(INST_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .count(count), .capture(capture), .pps_seen(pps_seen),
    .staged(staged), .ctrl_wr(ctrl_wr), .load_now(load_now), .arm_set(arm_set)
  );

  // An arm only exists after a control write asking for it.
  p_arm_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(arm_set));
endmodule

// File: tb/tick_timebase_tb.sv
`timescale 1ns/1ps
module tick_timebase_tb;
  localparam int WIN_LO = 148;

  logic        clk = 1'b0, rst = 1'b1, pps = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  tick_timebase #(.INST_IDX(1)) u_dut (
    .clk(clk), .rst(rst), .pps_in(pps), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, last_edge = 0, base_edge = 0;
  bit done = 0;
  logic [63:0] base_val = '0, cap_exp = '0, e = '0;
  logic [31:0] rdv;
  logic        rvv;

  // {is_write, word, wdata, expected read}
  localparam logic [68:0] VEC [0:11] = '{
    {1'b1, 4'd7,  32'h12345678, 32'h0},
    {1'b1, 4'd8,  32'h9ABCDEF0, 32'h0},
    {1'b0, 4'd7,  32'h0, 32'h12345678},
    {1'b0, 4'd8,  32'h0, 32'h9ABCDEF0},
    {1'b1, 4'd7,  32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd7,  32'h0, 32'hFFFFFFFF},
    {1'b0, 4'd8,  32'h0, 32'h9ABCDEF0},
    {1'b1, 4'd2,  32'hAAAA5555, 32'h0},
    {1'b0, 4'd2,  32'h0, 32'h0},
    {1'b1, 4'd5,  32'h0000DEAD, 32'h0},
    {1'b0, 4'd5,  32'h0, 32'h0},
    {1'b0, 4'd10, 32'h0, 32'h0}
  };

  function automatic logic [63:0] exp_now(int r);
    return base_val + 64'(r - base_edge - 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_addr(logic [15:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; last_edge = cyc;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_addr(logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1; last_edge = cyc; rdv = bus_rdata; rvv = bus_rvalid;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(int w, logic [31:0] d); wr_addr(16'(WIN_LO + 4*w), d); endtask
  task automatic rd(int w); rd_addr(16'(WIN_LO + 4*w)); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic load_now_check(logic [63:0] v);
    wr(2, v[31:0]); wr(3, v[63:32]); wr(4, 32'h1);
    base_val = v; base_edge = last_edge;
  endtask

  // Raise PPS at a falling edge; the synchronized edge acts three posedges later.
  task automatic pps_pulse(bit loads, logic [63:0] v);
    pps = 1'b1;
    cap_exp = exp_now(cyc + 3);
    if (loads) begin base_val = v; base_edge = cyc + 3; end
    idle(4); pps = 1'b0; idle(4);
  endtask

  task automatic check_now(string req);
    rd(0); e = exp_now(last_edge); check(req, rdv, e[31:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0; base_val = '0; base_edge = cyc;

    // Reset state
    check_now("R10 count after reset");
    rd(7); check("R10 period lo reset", rdv, 32'h0);
    rd(8); check("R10 period hi reset", rdv, 32'h0);
    rd(5); check("R10 capture reset", rdv, 32'h0);
    rd(9); check("R10 detect bit reset", rdv, 32'h0);

    // Register table walk
    for (int i = 0; i < 12; i++) begin
      string req;
      case (VEC[i][67:64])
        4'd7, 4'd8: req = "R8 table";
        4'd2:       req = "R4 table";
        4'd5:       req = "R10 table";
        default:    req = "R1 table";
      endcase
      if (VEC[i][68]) wr(int'(VEC[i][67:64]), VEC[i][63:32]);
      else begin
        rd(int'(VEC[i][67:64]));
        check(req, rdv, VEC[i][31:0]);
      end
    end

    // Free run and read response
    check_now("R2 free count");
    check("R2 rvalid", {31'b0, rvv}, 32'h1);
    rd(1); check("R3 high word", rdv, 32'h0);

    // Window decode
    rd_addr(16'(100 + 28)); check("R1 other window rvalid", {31'b0, rvv}, 32'h0);
    check("R1 other window data", rdv, 32'h0);
    wr_addr(16'(100 + 28), 32'h55);
    rd(7); check("R1 foreign write ignored", rdv, 32'hFFFFFFFF);
    rd_addr(16'(WIN_LO + 48)); check("R1 past window", {31'b0, rvv}, 32'h0);
    rd_addr(16'(WIN_LO + 44)); check("R1 last word rvalid", {31'b0, rvv}, 32'h1);
    check("R1 unmapped data", rdv, 32'h0);
    wr(0, 32'h0BAD0BAD);
    check_now("R10 write to count ignored");

    // Immediate load and coherent 64-bit read across a carry
    load_now_check(64'h00000005_FFFFFFFF);
    check_now("R4 immediate load");
    rd(1); check("R3 latched high across carry", rdv, 32'h5);
    idle(3);
    rd(1); check("R3 shadow not live", rdv, 32'h5);

    // Unarmed PPS: capture and detect only
    pps_pulse(1'b0, '0);
    rd(5); check("R7 capture lo", rdv, cap_exp[31:0]);
    rd(6); check("R7 capture hi", rdv, cap_exp[63:32]);
    check_now("R7 unarmed edge no load");
    rd(9); check("R9 detect toggled", rdv, 32'h1);

    // Armed load waits for the edge
    wr(2, 32'h00000100); wr(3, 32'h00000010); wr(4, 32'h2);
    idle(12);
    check_now("R5 arm pending");
    pps_pulse(1'b1, 64'h00000010_00000100);
    check_now("R5 load on edge");
    rd(1); check("R5 high after edge", rdv, 32'h10);
    rd(9); check("R9 detect toggled back", rdv, 32'h0);
    rd(5); check("R7 capture on armed edge", rdv, cap_exp[31:0]);

    // Cancel with 0x0
    wr(2, 32'h00007000); wr(3, 32'h3); wr(4, 32'h2); wr(4, 32'h0);
    pps_pulse(1'b0, '0);
    check_now("R6 cancel by zero");
    rd(1); e = exp_now(last_edge - 1); check("R6 high after cancel", rdv, e[63:32]);

    // Cancel with an immediate load
    wr(4, 32'h2);
    load_now_check(64'h00000003_00007000);
    idle(6);
    pps_pulse(1'b0, '0);
    check_now("R6 cancel by load");
    rd(5); check("R7 capture after cancel", rdv, cap_exp[31:0]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule